// File: doc/BRIEF.md
# Dual-Port Semaphore Flag Unit

This block holds eight hardware semaphore flags that a left and a right processor port share. The flags are kept apart from any data memory. They only record which side holds each token and gate nothing in hardware; software decides what each flag guards. Each port has a chip enable, a semaphore enable, a 3-bit flag select, a write strobe with one data bit, and an 8-bit read path.

To take a token, a processor writes 0 to a flag and then reads that flag back. A read of all zeros means it holds the token. A read of all ones means the other side holds it. A request that loses stays pending inside the unit and is granted at the clock edge where the holder releases the flag. The losing side may instead withdraw its request by writing 1. Reads are combinational from the flag state, so no access ever stalls either port.

Top module: `sem_flag_unit`

## Requirements
- R1: After reset, whether applied at start-up or later while a flag is held, all eight flags are free and every read returns 8'hFF on both ports.
- R2: A port writes a flag only when `*_sem_en_i`=1, `*_ce_i`=0 and `*_we_i`=1. A write made with `*_sem_en_i`=0, or with `*_ce_i`=1, leaves every flag unchanged.
- R3: Writing data bit 0 requests the selected flag and writing 1 releases it. A request on a free flag is granted at the write clock edge.
- R4: A read is combinational from `*_sel_i`. It returns 8'h00 to the side that holds the flag and 8'hFF otherwise, so all data bits equal the flag bit.
- R5: A request from the side that does not hold a flag leaves the holder in place, and the request stays pending. A repeated request from the holder has no effect.
- R6: When the holder releases a flag while the other side has a pending request, the flag passes to that side at the same edge. This includes a release and a request made in the same cycle.
- R7: When both sides request a free flag in the same cycle, the left port gets the flag and the right request stays pending.
- R8: A release from the side that does not hold a flag withdraws its pending request. A later release by the holder then leaves the flag free. A release of a free flag has no effect.
- R9: Flags are independent. An access to one select changes no other flag, and the two ports can hold different flags at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l_ce_i | input | 1 | Left chip enable for the memory array (must be 0 for a flag access) |
| l_sem_en_i | input | 1 | Left semaphore enable |
| l_sel_i | input | 3 | Left flag select |
| l_we_i | input | 1 | Left write strobe |
| l_wdata_i | input | 1 | Left write bit: 0 requests, 1 releases |
| l_rdata_o | output | 8 | Left read data: 8'h00 when left holds the flag, else 8'hFF |
| r_ce_i | input | 1 | Right chip enable for the memory array (must be 0 for a flag access) |
| r_sem_en_i | input | 1 | Right semaphore enable |
| r_sel_i | input | 3 | Right flag select |
| r_we_i | input | 1 | Right write strobe |
| r_wdata_i | input | 1 | Right write bit: 0 requests, 1 releases |
| r_rdata_o | output | 8 | Right read data: 8'h00 when right holds the flag, else 8'hFF |

## Verification
Assertions check on every cycle the ownership rules inside each flag: a holder that does not release keeps the flag, a release passes the flag to a pending requester or frees it, and a same-cycle tie goes to the left. They also check that a cycle with no valid write leaves all flags stable, that a port's decoded write touches at most one flag, and that each read word is uniform. Other behaviour shows up only in the bench's scenarios: the exact read values each side sees after request, release and withdraw sequences, the two illegal-write gates, the reset that clears a held flag, and independence across different selects.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic [1:0] {
    OWN_FREE = 2'd0,
    OWN_L    = 2'd1,
    OWN_R    = 2'd2
  } owner_e;
endpackage

// File: rtl/sem_port_dec.sv
module sem_port_dec #(
  parameter int N_FLAGS = 8,
  localparam int SEL_W = $clog2(N_FLAGS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ce_i,
  input  logic               sem_en_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               we_i,
  input  logic               wdata_i,
  output logic [N_FLAGS-1:0] set_o,
  output logic [N_FLAGS-1:0] clr_o
);
  logic wr;
  // flag access needs the memory array deselected
  assign wr = we_i & sem_en_i & ~ce_i;

  always_comb begin
    set_o = '0;
    clr_o = '0;
    if (wr) begin
      if (wdata_i) clr_o[sel_i] = 1'b1;
      else         set_o[sel_i] = 1'b1;
    end
  end

  // R9
  one_flag_per_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(set_o | clr_o));
endmodule

// File: rtl/sem_flag_cell.sv
module sem_flag_cell
  import sem_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   set_l_i,
  input  logic   clr_l_i,
  input  logic   set_r_i,
  input  logic   clr_r_i,
  output owner_e owner_o
);
  logic   req_l_q, req_r_q, req_l_n, req_r_n;
  owner_e owner_q, owner_n;

  assign req_l_n = set_l_i ? 1'b1 : (clr_l_i ? 1'b0 : req_l_q);
  assign req_r_n = set_r_i ? 1'b1 : (clr_r_i ? 1'b0 : req_r_q);

  always_comb begin
    unique case (owner_q)
      OWN_L:   owner_n = req_l_n ? OWN_L : (req_r_n ? OWN_R : OWN_FREE);
      OWN_R:   owner_n = req_r_n ? OWN_R : (req_l_n ? OWN_L : OWN_FREE);
      default: owner_n = req_l_n ? OWN_L : (req_r_n ? OWN_R : OWN_FREE); // left wins a tie
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_l_q <= 1'b0;
      req_r_q <= 1'b0;
      owner_q <= OWN_FREE;
    end else begin
      req_l_q <= req_l_n;
      req_r_q <= req_r_n;
      owner_q <= owner_n;
    end
  end

  assign owner_o = owner_q;

  // R5
  holder_keeps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == OWN_L && !clr_l_i) |=> owner_q == OWN_L);
  // R6
  pass_on_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == OWN_L && clr_l_i && (req_r_q || set_r_i) && !clr_r_i) |=> owner_q == OWN_R);
  // R7
  left_wins_tie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == OWN_FREE && set_l_i && set_r_i) |=> (owner_q == OWN_L && req_r_q));
  // R8
  free_on_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == OWN_R && clr_r_i && !set_l_i && (!req_l_q || clr_l_i)) |=> owner_q == OWN_FREE);
endmodule

// File: rtl/sem_flag_unit.sv
module sem_flag_unit
  import sem_pkg::*;
#(
  parameter int N_FLAGS = 8,
  parameter int DATA_W  = 8,
  localparam int SEL_W  = $clog2(N_FLAGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              l_ce_i,
  input  logic              l_sem_en_i,
  input  logic [SEL_W-1:0]  l_sel_i,
  input  logic              l_we_i,
  input  logic              l_wdata_i,
  output logic [DATA_W-1:0] l_rdata_o,
  input  logic              r_ce_i,
  input  logic              r_sem_en_i,
  input  logic [SEL_W-1:0]  r_sel_i,
  input  logic              r_we_i,
  input  logic              r_wdata_i,
  output logic [DATA_W-1:0] r_rdata_o
);
  logic   [N_FLAGS-1:0] l_set, l_clr, r_set, r_clr;
  owner_e [N_FLAGS-1:0] owner_w;

  sem_port_dec #(.N_FLAGS(N_FLAGS)) u_dec_l (
    .clk_i, .rst_ni, .ce_i(l_ce_i), .sem_en_i(l_sem_en_i), .sel_i(l_sel_i),
    .we_i(l_we_i), .wdata_i(l_wdata_i), .set_o(l_set), .clr_o(l_clr));

  sem_port_dec #(.N_FLAGS(N_FLAGS)) u_dec_r (
    .clk_i, .rst_ni, .ce_i(r_ce_i), .sem_en_i(r_sem_en_i), .sel_i(r_sel_i),
    .we_i(r_we_i), .wdata_i(r_wdata_i), .set_o(r_set), .clr_o(r_clr));

  for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
    sem_flag_cell u_cell (
      .clk_i, .rst_ni,
      .set_l_i(l_set[g]), .clr_l_i(l_clr[g]),
      .set_r_i(r_set[g]), .clr_r_i(r_clr[g]),
      .owner_o(owner_w[g]));
  end

  // flag bit replicated over the read word
  assign l_rdata_o = {DATA_W{owner_w[l_sel_i] != OWN_L}};
  assign r_rdata_o = {DATA_W{owner_w[r_sel_i] != OWN_R}};

  // R2
  idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_set == '0 && l_clr == '0 && r_set == '0 && r_clr == '0) |=> $stable(owner_w));
  // R4
  uniform_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_rdata_o == '0 || l_rdata_o == '1) && (r_rdata_o == '0 || r_rdata_o == '1));
  // R4
  not_both_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_sel_i == r_sel_i) |-> !(l_rdata_o == '0 && r_rdata_o == '0));
endmodule

// File: tb/sim_sem_flag_unit.sv
`timescale 1ns/1ps
module sim_sem_flag_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       l_ce, l_sem, l_we, l_wd, r_ce, r_sem, r_we, r_wd;
  logic [2:0] l_sel, r_sel;
  logic [7:0] l_rd, r_rd;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  sem_flag_unit u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .l_ce_i(l_ce), .l_sem_en_i(l_sem), .l_sel_i(l_sel), .l_we_i(l_we), .l_wdata_i(l_wd), .l_rdata_o(l_rd),
    .r_ce_i(r_ce), .r_sem_en_i(r_sem), .r_sel_i(r_sel), .r_we_i(r_we), .r_wdata_i(r_wd), .r_rdata_o(r_rd));

  // ops: 0 idle, 1 request, 2 release, 3 request with ce=1 (must be ignored)
  // vector: [15:12] requirement, [11:10] l_op, [9:7] l_sel, [6:5] r_op, [4:2] r_sel, [1] exp_l, [0] exp_r
  localparam int NV = 20;
  localparam logic [15:0] VEC [NV] = '{
    {4'd3, 2'd1, 3'd0, 2'd0, 3'd0, 1'b0, 1'b1}, // R3 left takes free flag
    {4'd5, 2'd0, 3'd0, 2'd1, 3'd0, 1'b0, 1'b1}, // R5 right pending
    {4'd6, 2'd2, 3'd0, 2'd0, 3'd0, 1'b1, 1'b0}, // R6 passes to right
    {4'd3, 2'd0, 3'd0, 2'd2, 3'd0, 1'b1, 1'b1}, // R3 release frees
    {4'd7, 2'd1, 3'd1, 2'd1, 3'd1, 1'b0, 1'b1}, // R7 tie to left
    {4'd6, 2'd2, 3'd1, 2'd0, 3'd1, 1'b1, 1'b0}, // R6
    {4'd3, 2'd0, 3'd1, 2'd2, 3'd1, 1'b1, 1'b1}, // R3
    {4'd2, 2'd3, 3'd2, 2'd0, 3'd2, 1'b1, 1'b1}, // R2 ce=1 write ignored
    {4'd9, 2'd1, 3'd4, 2'd1, 3'd3, 1'b0, 1'b0}, // R9 different flags held
    {4'd9, 2'd0, 3'd3, 2'd0, 3'd4, 1'b1, 1'b1}, // R9 cross reads
    {4'd5, 2'd0, 3'd4, 2'd1, 3'd4, 1'b0, 1'b1}, // R5
    {4'd8, 2'd0, 3'd4, 2'd2, 3'd4, 1'b0, 1'b1}, // R8 withdraw
    {4'd8, 2'd2, 3'd4, 2'd0, 3'd4, 1'b1, 1'b1}, // R8 nothing pending
    {4'd3, 2'd0, 3'd3, 2'd2, 3'd3, 1'b1, 1'b1}, // R3
    {4'd3, 2'd1, 3'd5, 2'd0, 3'd5, 1'b0, 1'b1}, // R3
    {4'd5, 2'd1, 3'd5, 2'd0, 3'd5, 1'b0, 1'b1}, // R5 re-request
    {4'd6, 2'd2, 3'd5, 2'd1, 3'd5, 1'b1, 1'b0}, // R6 same-cycle hand-over
    {4'd3, 2'd0, 3'd5, 2'd2, 3'd5, 1'b1, 1'b1}, // R3
    {4'd8, 2'd2, 3'd7, 2'd0, 3'd7, 1'b1, 1'b1}, // R8 release of free flag
    {4'd2, 2'd0, 3'd6, 2'd3, 3'd6, 1'b1, 1'b1}  // R2
  };

  task automatic chk(input int req, input string what, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL R%0d %s: got=%h exp=%h", req, what, got, exp);
    end
  endtask

  task automatic drv_l(input logic [1:0] op, input logic [2:0] sel);
    l_sel = sel; l_sem = 1'b1; l_ce = (op == 2'd3); l_we = (op != 2'd0); l_wd = (op == 2'd2);
  endtask

  task automatic drv_r(input logic [1:0] op, input logic [2:0] sel);
    r_sel = sel; r_sem = 1'b1; r_ce = (op == 2'd3); r_we = (op != 2'd0); r_wd = (op == 2'd2);
  endtask

  task automatic read_mode();
    l_we = 1'b0; r_we = 1'b0; l_ce = 1'b0; r_ce = 1'b0; l_sem = 1'b1; r_sem = 1'b1;
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    drv_l(2'd0, 3'd0); drv_r(2'd0, 3'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state of every flag
    for (int s = 0; s < 8; s++) begin
      l_sel = 3'(s); r_sel = 3'(7 - s); #2;
      chk(1, "reset left", l_rd, 8'hFF);
      chk(1, "reset right", r_rd, 8'hFF);
    end
    // vector walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drv_l(VEC[i][11:10], VEC[i][9:7]);
      drv_r(VEC[i][6:5], VEC[i][4:2]);
      @(negedge clk);
      read_mode(); #5;
      chk(int'(VEC[i][15:12]), $sformatf("vec %0d left", i), l_rd, {8{VEC[i][1]}});
      chk(int'(VEC[i][15:12]), $sformatf("vec %0d right", i), r_rd, {8{VEC[i][0]}});
    end
    // R2 write with semaphore enable low
    @(negedge clk);
    l_sel = 3'd2; l_sem = 1'b0; l_ce = 1'b0; l_we = 1'b1; l_wd = 1'b0;
    @(negedge clk);
    read_mode(); #5;
    chk(2, "sem_en low write", l_rd, 8'hFF);
    // R4 combinational read: select change without a clock edge
    @(negedge clk);
    drv_l(2'd1, 3'd6);
    @(negedge clk);
    read_mode(); #2;
    chk(4, "owned read", l_rd, 8'h00);
    l_sel = 3'd0; #2;
    chk(4, "other select read", l_rd, 8'hFF);
    r_sel = 3'd6; #2;
    chk(4, "right sees held", r_rd, 8'hFF);
    // R1 reset while a flag is held
    l_sel = 3'd6; #2;
    rst_n = 1'b0; #3;
    chk(1, "mid reset left", l_rd, 8'hFF);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #2;
    chk(1, "after reset right", r_rd, 8'hFF);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule